// File: doc/BRIEF.md
# Programmable Up/Down Step Counter

A synchronous counter whose width is a parameter (8 bits by default). Each enabled advance adds or subtracts a step size that is taken from an input. The direction input picks addition or subtraction. The count can be overwritten from an external value at any clock. All state changes happen on the rising clock edge, and arithmetic wraps modulo 2^WIDTH.

In free-running mode the counter advances on every enabled clock. In single-step mode it advances once for each rising transition of a strobe input, so a strobe held high for many clocks still produces exactly one move. A build parameter turns the reset of the count register from synchronous into asynchronous.

Top module: `step_counter`

## Requirements
- R1: While `rst` is 1 at a rising edge, `count` becomes 0 at that edge, whatever the other inputs are.
- R2: With `rst` at 0 and `load` at 1, `count` takes `load_val` at the edge. Load overrides every advance and also applies while `en` is 0.
- R3: With `en`=1, `single_mode`=0 and no load, `count` changes at every edge. `up`=1 adds `step` and `up`=0 subtracts `step`.
- R4: Addition and subtraction wrap modulo 2^WIDTH without saturating. For example, with WIDTH=4: 14+3 gives 1 and 2-5 gives 13.
- R5: A `step` of 0 leaves `count` unchanged even when an advance is taken.
- R6: With `en`=0 and no load, `count` holds.
- R7: With `single_mode`=1, `count` advances (with R3's direction and step) only at an edge where `strobe` is 1 and was 0 at the previous edge. Holding `strobe` high gives exactly one advance.
- R8: A strobe rising edge that comes while `en` is 0, or while `load` or `rst` is 1, is discarded. It does not cause an advance later.
- R9: `strobe` is sampled at every edge, including reset edges. A strobe that is already high when reset is released causes no advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Reset of the count, active high |
| en | input | 1 | Allows advancing |
| up | input | 1 | 1 adds the step, 0 subtracts it |
| step | input | WIDTH | Step size per advance |
| load | input | 1 | Preload strobe |
| load_val | input | WIDTH | Value written on load |
| single_mode | input | 1 | 1 selects strobe-driven single stepping |
| strobe | input | 1 | Single-step strobe (acts on its rising edge) |
| count | output | WIDTH | Current count |

## Verification
Every result appears at the first rising edge after the inputs that cause it: reset, load and advance are each one register away from `count`. The strobe rising edge uses the level sampled at the previous edge, so it reaches the count within that same single edge. The bench drives inputs 2 ns after an edge and computes the expected value from the values driven. It then compares `count` 2 ns after the following edge, so each stimulus is checked exactly one cycle later. The sweep covers every preload value, every step and both directions at WIDTH=4, and then runs sequences aimed at the strobe-history cases.

// File: rtl/step_counter.sv
module step_counter #(
  parameter int WIDTH     = 8,
  parameter bit ASYNC_RST = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             up,
  input  logic [WIDTH-1:0] step,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  input  logic             single_mode,
  input  logic             strobe,
  output logic [WIDTH-1:0] count
);

  logic [WIDTH-1:0] count_q;
  logic [WIDTH-1:0] stepped;
  logic [WIDTH-1:0] count_d;
  logic             strobe_q;
  logic             rise;
  logic             advance;

  assign rise    = strobe & ~strobe_q;
  assign advance = en & (~single_mode | rise);
  assign stepped = up ? count_q + step : count_q - step;
  assign count_d = load ? load_val : (advance ? stepped : count_q);
  assign count   = count_q;

  always_ff @(posedge clk) strobe_q <= strobe;

  generate
    if (ASYNC_RST) begin : g_async
      always_ff @(posedge clk or posedge rst)
        if (rst) count_q <= '0;
        else     count_q <= count_d;
    end else begin : g_sync
      always_ff @(posedge clk)
        if (rst) count_q <= '0;
        else     count_q <= count_d;
    end
  endgenerate

endmodule

// File: rtl/step_counter_chk.sv
module step_counter_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             up,
  input logic [WIDTH-1:0] step,
  input logic             load,
  input logic [WIDTH-1:0] load_val,
  input logic             single_mode,
  input logic             strobe,
  input logic [WIDTH-1:0] count
);

  logic seen_strobe;
  always_ff @(posedge clk) seen_strobe <= strobe;

  assert_reset_zero_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> count == '0);

  assert_load_value_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> count == $past(load_val));

  assert_count_up_R3_R4: assert property (@(posedge clk) disable iff (rst)
    (!load && en && !single_mode && up) |=> count == WIDTH'($past(count) + $past(step)));

  assert_count_down_R3_R4: assert property (@(posedge clk) disable iff (rst)
    (!load && en && !single_mode && !up) |=> count == WIDTH'($past(count) - $past(step)));

  assert_zero_step_R5: assert property (@(posedge clk) disable iff (rst)
    (!load && step == '0) |=> $stable(count));

  assert_disabled_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!load && !en) |=> $stable(count));

  assert_single_no_edge_R7: assert property (@(posedge clk) disable iff (rst)
    (!load && single_mode && !(strobe && !seen_strobe)) |=> $stable(count));

endmodule

bind step_counter step_counter_chk #(.WIDTH(WIDTH)) u_step_counter_chk (
  .clk(clk), .rst(rst), .en(en), .up(up), .step(step), .load(load),
  .load_val(load_val), .single_mode(single_mode), .strobe(strobe), .count(count)
);

// File: tb/test_step_counter.sv
module test_step_counter;
  localparam int W = 4;
  localparam int M = 1 << W;

  logic clk = 1'b0, rst = 1'b1, en = 1'b0, up = 1'b1, load = 1'b0;
  logic single_mode = 1'b0, strobe = 1'b0;
  logic [W-1:0] step = '0, load_val = '0;
  wire  [W-1:0] count;

  int compared = 0, mismatched = 0;
  bit done = 1'b0;
  logic [W-1:0] exp_cnt = '0;
  logic exp_prev = 1'b0;

  step_counter #(.WIDTH(W)) i_step_counter (
    .clk(clk), .rst(rst), .en(en), .up(up), .step(step), .load(load),
    .load_val(load_val), .single_mode(single_mode), .strobe(strobe), .count(count)
  );

  always #10 clk = ~clk;

  task automatic cycle(input string req);
    logic [W-1:0] nxt;
    logic rise;
    rise = strobe && !exp_prev;
    if (rst) nxt = '0;
    else if (load) nxt = load_val;
    else if (en && (!single_mode || rise)) nxt = up ? W'(exp_cnt + step) : W'(exp_cnt - step);
    else nxt = exp_cnt;
    exp_prev = strobe;
    @(posedge clk);
    #2;
    exp_cnt = nxt;
    compared++;
    if (count !== exp_cnt) begin
      mismatched++;
      $display("FAIL %s: count=%0d expected %0d", req, count, exp_cnt);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    mismatched++;
    compared++;
    $display("FAIL watchdog: count=%0d expected completion", count);
    summary();
  end

  initial begin
    // R1: reset with load and enable active still yields zero
    rst = 1; load = 1; load_val = 4'd9; en = 1; step = 4'd3;
    cycle("R1");
    cycle("R1");
    rst = 0; load = 0; en = 0;

    // R2 R3 R4 R5: every preload, step and direction
    for (int d = 0; d < 2; d++) begin
      for (int s = 0; s < M; s++) begin
        for (int v = 0; v < M; v++) begin
          up = d[0]; step = W'(s); load_val = W'(v);
          load = 1; en = 1; single_mode = 0;
          cycle("R2");
          load = 0;
          for (int k = 0; k < 4; k++) cycle(s == 0 ? "R5" : "R3 R4");
        end
      end
    end

    // R4: explicit wrap corners
    load = 1; load_val = 4'd14; cycle("R2"); load = 0;
    up = 1; step = 4'd3; cycle("R4");
    load = 1; load_val = 4'd2; cycle("R2"); load = 0;
    up = 0; step = 4'd5; cycle("R4");

    // R6: disabled holds, load still applies
    en = 0; step = 4'd1;
    for (int k = 0; k < 3; k++) cycle("R6");
    load = 1; load_val = 4'd7; cycle("R2 R6"); load = 0;
    cycle("R6");

    // R7: single mode, held strobe gives one advance
    en = 1; single_mode = 1; up = 1; step = 4'd2;
    cycle("R7");
    strobe = 1;
    for (int k = 0; k < 5; k++) cycle("R7");
    strobe = 0; cycle("R7");
    for (int k = 0; k < 4; k++) begin
      strobe = 1; cycle("R7");
      strobe = 0; cycle("R7");
    end
    up = 0; strobe = 1; cycle("R7"); strobe = 0; cycle("R7");

    // R8: rise while disabled is lost
    en = 0; strobe = 1; cycle("R8");
    en = 1; cycle("R8"); cycle("R8");
    strobe = 0; cycle("R8");
    // R8: rise together with load is lost
    load = 1; load_val = 4'd5; strobe = 1; cycle("R2 R8");
    load = 0; cycle("R8"); cycle("R8");
    strobe = 0; cycle("R8");

    // R9: strobe high through reset release
    rst = 1; strobe = 1; cycle("R1 R9");
    rst = 0; cycle("R9"); cycle("R9");
    strobe = 0; cycle("R9");
    strobe = 1; cycle("R7 R9");

    summary();
  end
endmodule